// File: doc/BRIEF.md
# Endpoint DMA Enable Register Bank

This block keeps one DMA enable bit for each endpoint of a device-side bus controller and exposes it to software through a small word-addressed register bus. Software enables endpoints by writing ones to a set port and disables them by writing ones to a clear port. A status word reads back the live enable vector, and a read-only summary word shows which of the interrupt status words hold any set bit. The two control endpoints at bit positions 0 and 1 never take part in DMA, so their bits stay zero whatever is written.

The DMA engine reports per-endpoint busy, done and error signals. A clear request for an endpoint with a transfer in flight is held as pending and takes effect on the cycle that endpoint's done pulse arrives. An error drops the enable at once. Any write to the clear port also drops a proceed flag. The descriptor-fetch logic sets that flag with a one-cycle pulse and reads it to decide whether it may skip a fetch.

Top module: `ep_dma_enable_bank`

## Requirements
- R1: A bus write to word address 1 (set port) with data bit i = 1 enables endpoint i (i >= 2) from the next cycle. Data bits that are 0 leave their endpoints unchanged.
- R2: A write to word address 2 (clear port) with bit i = 1 disables endpoint i on the next cycle when that endpoint is not busy. Data bits that are 0 leave their endpoints unchanged.
- R3: Enable bits 0 and 1 (control OUT and control IN) are never set and always read as 0.
- R4: During and after reset every enable bit, every pending clear and the proceed flag are 0.
- R5: A clear of an enabled, busy endpoint with no done pulse in that cycle leaves the endpoint enabled, and records a pending clear. The enable drops on the cycle after the endpoint's done pulse. A clear in the same cycle as a done pulse takes effect at once.
- R6: An error pulse for an endpoint disables it on the next cycle and cancels any pending clear.
- R7: A set write is ignored for an endpoint that has a pending clear or an error pulse in the same cycle.
- R8: Any write to the clear port, whatever its data, makes proceed 0 on the next cycle. This overrides a same-cycle proceed-set pulse.
- R9: A proceed-set pulse with no clear-port write sets proceed on the next cycle. Otherwise proceed holds its value.
- R10: Reading word address 3 returns a summary in which bit k is 1 exactly when interrupt status word k (bits 32k to 32k+31 of the status input) is nonzero. Bits at and above the number of status words read as 0. A write to this address changes nothing.
- R11: Read data is combinational on the address. Address 0 returns the enable vector. Addresses 1 and 2 are write-only and read as 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| regAddr | input | 2 | Word address: 0 status, 1 set, 2 clear, 3 summary |
| regWrEn | input | 1 | Write strobe for the addressed word |
| regWrData | input | 32 | Write data |
| regRdData | output | 32 | Read data for the addressed word |
| xferBusy | input | 32 | Per-endpoint transfer in progress |
| xferDone | input | 32 | Per-endpoint transfer completion pulse |
| xferErr | input | 32 | Per-endpoint transfer error pulse |
| proceedSet | input | 1 | Pulse from descriptor logic setting the proceed flag |
| intStatusFlat | input | 96 | Three 32-bit interrupt status words, word k at bits 32k+31:32k |
| dmaEnable | output | 32 | Effective per-endpoint DMA enable vector |
| proceed | output | 1 | Descriptor-fetch proceed flag |

## Verification
The bench uses the default parameters: 32 endpoints, two control endpoints and three interrupt status words. Because the endpoint count equals the bus width, every data bit maps to an endpoint, and a random write reaches both control bits as well as the top endpoint. Three status words leave summary bits above the populated ones, so the zero fill is observable. Random busy, done and error vectors overlap deferred clears with completions, errors and new set writes in the same cycle, and every cycle is compared against a behavioural model.

// File: rtl/ep_dma_pkg.sv
package ep_dma_pkg;
  localparam int ADDR_W = 2;

  typedef enum logic [ADDR_W-1:0] {
    ADDR_STATUS  = 2'd0,
    ADDR_SET     = 2'd1,
    ADDR_CLEAR   = 2'd2,
    ADDR_SUMMARY = 2'd3
  } regSel_e;

  typedef struct packed {
    logic setStb;
    logic clrStb;
    logic rdStatus;
    logic rdSummary;
  } strobes_t;
endpackage

// File: rtl/ep_dma_bus_ctrl.sv
module ep_dma_bus_ctrl
  import ep_dma_pkg::*;
(
  input  logic              regWrEn,
  input  logic [ADDR_W-1:0] regAddr,
  output strobes_t          stb
);
  regSel_e sel;

  always_comb begin
    sel           = regSel_e'(regAddr);
    stb.setStb    = regWrEn && (sel == ADDR_SET);
    stb.clrStb    = regWrEn && (sel == ADDR_CLEAR);
    stb.rdStatus  = (sel == ADDR_STATUS);
    stb.rdSummary = (sel == ADDR_SUMMARY);
  end
endmodule

// File: rtl/ep_dma_irq_summary.sv
module ep_dma_irq_summary #(
  parameter int NUM_SRC = 3,
  parameter int WORD_W  = 32,
  parameter int OUT_W   = 32
) (
  input  logic [NUM_SRC*WORD_W-1:0] statusFlat,
  output logic [OUT_W-1:0]          summary
);
  for (genvar k = 0; k < OUT_W; k++) begin : g_bit
    if (k < NUM_SRC) begin : g_live
      assign summary[k] = |statusFlat[k*WORD_W +: WORD_W];
    end else begin : g_zero
      assign summary[k] = 1'b0;
    end
  end
endmodule

// File: rtl/ep_dma_enable_dp.sv
module ep_dma_enable_dp
  import ep_dma_pkg::*;
#(
  parameter int NUM_EP   = 32,
  parameter int NUM_CTRL = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  strobes_t          stb,
  input  logic [NUM_EP-1:0] wrBits,
  input  logic [NUM_EP-1:0] xferBusy,
  input  logic [NUM_EP-1:0] xferDone,
  input  logic [NUM_EP-1:0] xferErr,
  input  logic              proceedSet,
  output logic [NUM_EP-1:0] enOut,
  output logic              proceed
);
  logic proceedQ;

  for (genvar i = 0; i < NUM_EP; i++) begin : g_ep
    localparam bit CanDma = (i >= NUM_CTRL);
    logic enBit, pendBit;
    logic setReq, clrReq, clearNow, holdEn, nextEn, nextPend;

    always_comb begin
      setReq   = stb.setStb & wrBits[i];
      clrReq   = stb.clrStb & wrBits[i];
      clearNow = xferErr[i]
               | (clrReq & (~xferBusy[i] | xferDone[i] | ~enBit))
               | (pendBit & xferDone[i]);
      holdEn   = clrReq | pendBit;
      nextEn   = enBit;
      nextPend = pendBit;
      if (clearNow) begin
        nextEn   = 1'b0;
        nextPend = 1'b0;
      end else if (holdEn) begin
        nextPend = 1'b1;
      end else if (setReq) begin
        nextEn = 1'b1;
      end
    end

    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        enBit   <= 1'b0;
        pendBit <= 1'b0;
      end else begin
        enBit   <= CanDma & nextEn;
        pendBit <= CanDma & nextPend;
      end
    end

    assign enOut[i] = enBit;

    if (CanDma) begin : g_chk
      assert_set_R1: assert property (@(posedge clk) disable iff (!rstN)
        (setReq && !pendBit && !xferErr[i]) |=> enBit);
      assert_idle_clear_R2: assert property (@(posedge clk) disable iff (!rstN)
        (clrReq && !xferBusy[i]) |=> !enBit);
      assert_defer_R5: assert property (@(posedge clk) disable iff (!rstN)
        (clrReq && enBit && xferBusy[i] && !xferDone[i] && !xferErr[i]) |=> (enBit && pendBit));
      assert_done_R5: assert property (@(posedge clk) disable iff (!rstN)
        (pendBit && xferDone[i]) |=> !enBit);
      assert_err_R6: assert property (@(posedge clk) disable iff (!rstN)
        xferErr[i] |=> (!enBit && !pendBit));
    end else begin : g_ctrl_chk
      assert_ctrl_R3: assert property (@(posedge clk) disable iff (!rstN)
        (stb.setStb && wrBits[i]) |=> !enBit);
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)               proceedQ <= 1'b0;
    else if (stb.clrStb)     proceedQ <= 1'b0;
    else if (proceedSet)     proceedQ <= 1'b1;
  end

  assign proceed = proceedQ;

  assert_proceed_drop_R8: assert property (@(posedge clk) disable iff (!rstN)
    stb.clrStb |=> !proceed);
  assert_proceed_set_R9: assert property (@(posedge clk) disable iff (!rstN)
    (proceedSet && !stb.clrStb) |=> proceed);
  assert_proceed_hold_R9: assert property (@(posedge clk) disable iff (!rstN)
    (!proceedSet && !stb.clrStb) |=> $stable(proceed));
endmodule

// File: rtl/ep_dma_enable_bank.sv
module ep_dma_enable_bank
  import ep_dma_pkg::*;
#(
  parameter int NUM_EP      = 32,
  parameter int NUM_CTRL    = 2,
  parameter int DATA_W      = 32,
  parameter int NUM_INT_SRC = 3
) (
  input  logic                          clk,
  input  logic                          rstN,
  input  logic [ADDR_W-1:0]             regAddr,
  input  logic                          regWrEn,
  input  logic [DATA_W-1:0]             regWrData,
  output logic [DATA_W-1:0]             regRdData,
  input  logic [NUM_EP-1:0]             xferBusy,
  input  logic [NUM_EP-1:0]             xferDone,
  input  logic [NUM_EP-1:0]             xferErr,
  input  logic                          proceedSet,
  input  logic [NUM_INT_SRC*DATA_W-1:0] intStatusFlat,
  output logic [NUM_EP-1:0]             dmaEnable,
  output logic                          proceed
);
  localparam int SUM_W = DATA_W;

  strobes_t          stb;
  logic [SUM_W-1:0]  summary;
  logic [DATA_W-1:0] statusWord;

  ep_dma_bus_ctrl u_ctrl (
    .regWrEn (regWrEn),
    .regAddr (regAddr),
    .stb     (stb)
  );

  ep_dma_enable_dp #(
    .NUM_EP   (NUM_EP),
    .NUM_CTRL (NUM_CTRL)
  ) u_dp (
    .clk        (clk),
    .rstN       (rstN),
    .stb        (stb),
    .wrBits     (regWrData[NUM_EP-1:0]),
    .xferBusy   (xferBusy),
    .xferDone   (xferDone),
    .xferErr    (xferErr),
    .proceedSet (proceedSet),
    .enOut      (dmaEnable),
    .proceed    (proceed)
  );

  ep_dma_irq_summary #(
    .NUM_SRC (NUM_INT_SRC),
    .WORD_W  (DATA_W),
    .OUT_W   (SUM_W)
  ) u_sum (
    .statusFlat (intStatusFlat),
    .summary    (summary)
  );

  always_comb begin
    statusWord = '0;
    statusWord[NUM_EP-1:0] = dmaEnable;
    if (stb.rdStatus)       regRdData = statusWord;
    else if (stb.rdSummary) regRdData = summary;
    else                    regRdData = '0;
  end

  assert_ctrl_bits_R3: assert property (@(posedge clk) disable iff (!rstN)
    stb.setStb |=> (dmaEnable[NUM_CTRL-1:0] == '0));
  assert_write_only_R11: assert property (@(posedge clk) disable iff (!rstN)
    (!stb.rdStatus && !stb.rdSummary) |-> (regRdData == '0));
endmodule

// File: tb/ep_dma_enable_bank_tb.sv
`timescale 1ns/1ps
module ep_dma_enable_bank_tb;
  localparam int NEP = 32, NCTRL = 2, DW = 32, NSRC = 3;

  logic            clk = 1'b0;
  logic            rstN = 1'b0;
  logic [1:0]      regAddr = '0;
  logic            regWrEn = 1'b0;
  logic [DW-1:0]   regWrData = '0;
  logic [DW-1:0]   regRdData;
  logic [NEP-1:0]  xferBusy = '0, xferDone = '0, xferErr = '0;
  logic            proceedSet = 1'b0;
  logic [NSRC*DW-1:0] intStatusFlat = '0;
  logic [NEP-1:0]  dmaEnable;
  logic            proceed;

  int  errors = 0, checks = 0;
  bit  mEn[NEP], mPend[NEP];
  bit  mProc;
  bit  finished = 0;

  always #5 clk = ~clk;

  ep_dma_enable_bank u_dut (
    .clk(clk), .rstN(rstN), .regAddr(regAddr), .regWrEn(regWrEn),
    .regWrData(regWrData), .regRdData(regRdData), .xferBusy(xferBusy),
    .xferDone(xferDone), .xferErr(xferErr), .proceedSet(proceedSet),
    .intStatusFlat(intStatusFlat), .dmaEnable(dmaEnable), .proceed(proceed)
  );

  task automatic check(input string tag, input string what,
                       input logic [DW-1:0] act, input logic [DW-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual=%h expected=%h", tag, what, act, exp);
    end
  endtask

  function automatic logic [DW-1:0] modelEn();
    logic [DW-1:0] v = '0;
    for (int i = 0; i < NEP; i++) v[i] = mEn[i];
    return v;
  endfunction

  function automatic logic [DW-1:0] modelRead(input logic [1:0] a);
    logic [DW-1:0] v = '0;
    if (a == 2'd0) v = modelEn();
    else if (a == 2'd3)
      for (int k = 0; k < NSRC; k++) v[k] = (intStatusFlat[k*DW +: DW] != 0);
    return v;
  endfunction

  task automatic step(input logic [1:0] a, input logic we, input logic [DW-1:0] d,
                      input logic [NEP-1:0] busy, input logic [NEP-1:0] done,
                      input logic [NEP-1:0] err, input logic ps, input string tag);
    bit setW, clrW;
    regAddr = a; regWrEn = we; regWrData = d;
    xferBusy = busy; xferDone = done; xferErr = err; proceedSet = ps;
    #1;
    check(tag, "rdata", regRdData, modelRead(a));
    setW = we && (a == 2'd1);
    clrW = we && (a == 2'd2);
    for (int i = NCTRL; i < NEP; i++) begin
      bit s = setW && d[i];
      bit c = clrW && d[i];
      if (err[i] || (c && (!busy[i] || done[i] || !mEn[i])) || (mPend[i] && done[i])) begin
        mEn[i] = 0; mPend[i] = 0;
      end else if (c || mPend[i]) begin
        mPend[i] = 1;
      end else if (s) begin
        mEn[i] = 1;
      end
    end
    if (clrW) mProc = 0;
    else if (ps) mProc = 1;
    @(posedge clk);
    @(negedge clk);
    check(tag, "enable", dmaEnable, modelEn());
    check(tag, "proceed", {31'd0, proceed}, {31'd0, mProc});
  endtask

  task automatic idle(input string tag);
    step(2'd0, 1'b0, '0, '0, '0, '0, 1'b0, tag);
  endtask

  initial begin
    #2_000_000;
    if (!finished) begin
      errors++; checks++;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < NEP; i++) begin mEn[i] = 0; mPend[i] = 0; end
    mProc = 0;
    repeat (3) @(negedge clk);
    check("R4", "enable in reset", dmaEnable, '0);
    check("R4", "proceed in reset", {31'd0, proceed}, '0);
    rstN = 1'b1;
    idle("R4");
    // R11: write-only ports read 0
    step(2'd1, 1'b0, '0, '0, '0, '0, 1'b0, "R11");
    step(2'd2, 1'b0, '0, '0, '0, '0, 1'b0, "R11");
    // R1: set selected bits, zero write has no effect
    step(2'd1, 1'b1, 32'h0000_00F4, '0, '0, '0, 1'b0, "R1");
    step(2'd1, 1'b1, 32'h0, '0, '0, '0, 1'b0, "R1");
    idle("R11");
    // R3: control endpoints never enable
    step(2'd1, 1'b1, 32'hFFFF_FFFF, '0, '0, '0, 1'b0, "R3");
    idle("R3");
    // R2: idle clear, zero clear
    step(2'd2, 1'b1, 32'h0000_00F0, '0, '0, '0, 1'b0, "R2");
    step(2'd2, 1'b1, 32'h0, '0, '0, '0, 1'b0, "R2");
    // R9 / R8: proceed flag
    step(2'd0, 1'b0, '0, '0, '0, '0, 1'b1, "R9");
    idle("R9");
    step(2'd2, 1'b1, 32'h0, '0, '0, '0, 1'b0, "R8");
    step(2'd0, 1'b0, '0, '0, '0, '0, 1'b1, "R9");
    step(2'd2, 1'b1, 32'h0, '0, '0, '0, 1'b1, "R8");
    // R5: deferred clear on busy endpoint 8, same-cycle done on 9
    step(2'd2, 1'b1, 32'h0000_0100, 32'h0000_0300, 32'h0000_0000, '0, 1'b0, "R5");
    step(2'd0, 1'b0, '0, 32'h0000_0300, '0, '0, 1'b0, "R5");
    step(2'd2, 1'b1, 32'h0000_0200, 32'h0000_0300, 32'h0000_0200, '0, 1'b0, "R5");
    // R7: set ignored while clear pending
    step(2'd1, 1'b1, 32'h0000_0100, 32'h0000_0100, '0, '0, 1'b0, "R7");
    step(2'd0, 1'b0, '0, 32'h0000_0100, 32'h0000_0100, '0, 1'b0, "R5");
    idle("R5");
    // R6: error clears enabled and pending endpoints
    step(2'd1, 1'b1, 32'h0000_1C00, '0, '0, '0, 1'b0, "R1");
    step(2'd2, 1'b1, 32'h0000_1000, 32'h0000_1000, '0, '0, 1'b0, "R5");
    step(2'd0, 1'b0, '0, 32'h0000_1000, '0, 32'h0000_1400, 1'b0, "R6");
    step(2'd0, 1'b0, '0, '0, 32'h0000_1000, '0, 1'b0, "R6");
    // R7: error beats same-cycle set
    step(2'd1, 1'b1, 32'h0000_2000, '0, '0, 32'h0000_2000, 1'b0, "R7");
    // R10: interrupt summary
    intStatusFlat = {32'h8000_0000, 32'h0000_1000, 32'h0};
    step(2'd3, 1'b0, '0, '0, '0, '0, 1'b0, "R10");
    step(2'd3, 1'b1, 32'hFFFF_FFFF, '0, '0, '0, 1'b1, "R10");
    intStatusFlat = '0;
    step(2'd3, 1'b0, '0, '0, '0, '0, 1'b0, "R10");
    intStatusFlat = {32'h0, 32'h0, 32'h0000_0001};
    step(2'd3, 1'b0, '0, '0, '0, '0, 1'b0, "R10");
    idle("R11");
    // mixed random traffic
    for (int n = 0; n < 3000; n++) begin
      logic [1:0] a = 2'($urandom_range(0, 3));
      logic [NEP-1:0] b = $urandom & $urandom;
      logic [NEP-1:0] dn = $urandom & $urandom & $urandom;
      logic [NEP-1:0] er = $urandom & $urandom & $urandom & $urandom & $urandom;
      if (n % 7 == 0) intStatusFlat = {$urandom & $urandom & $urandom, 32'($urandom_range(0, 1)), $urandom};
      step(a, 1'($urandom_range(0, 1)), $urandom, b, dn, er, 1'($urandom_range(0, 3) == 0), "RND");
    end
    finished = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule